// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block stores image scan lines in a 5120-word by 8-bit array and plays them back on an independent clock. It is used to delay a video line by a chosen number of pixels, or to move line data between two parts of a chip that run at different rates. The write side and the read side each have their own clock, an active-low enable and an active-low synchronous reset. Neither side sees the other side's state.

Each side keeps a free-running address counter. The counter steps once per enabled clock and wraps from the last word back to word 0. A reset pulse returns the counter to 0, so the distance between a written word and its read-back is set only by when the two resets occur. No flags report full or empty, and nothing prevents overruns.

The read data comes from a register. A drive-enable output follows the read enable, so a three-state pad can float the bus while reading is paused.

Top module: `line_delay_mem`

## Requirements
- R1: A write clock edge with `wrst_n` low sets the write address to 0. The first word written after that cycle is stored in word 0, the next in word 1, and so on.
- R2: A write clock edge with `wrst_n` high and `we_n` high stores nothing and leaves the write address unchanged. Writing later resumes at that same address.
- R3: Each write clock edge with `wrst_n` high and `we_n` low stores `wdata` at the write address and advances the address by one. After word DEPTH-1 (5119) the address wraps to 0.
- R4: A read clock edge with `rrst_n` low sets the read address to 0. The next enabled read returns word 0.
- R5: Each read clock edge with `rrst_n` high and `re_n` low loads the word at the read address into the output register, which drives `rdata` after that edge. The same edge advances the read address by one, wrapping from 5119 to 0.
- R6: A read clock edge with `rrst_n` high and `re_n` high leaves the read address and the output register unchanged.
- R7: `rdata_oe` is 1 while `re_n` is low and 0 while `re_n` is high. While it is 1, `rdata` shows the word loaded by the last enabled read.
- R8: When reset and enable are active on the same edge, reset wins. A write-reset edge stores nothing. A read-reset edge does not load the output register.
- R9: The two sides run on unrelated clocks. A word written N writes after a write reset is returned by the Nth read after a read reset, whatever the gap between the two resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Synchronous write-address reset, active low |
| we_n | input | 1 | Write enable, active low |
| wdata | input | WIDTH | Write data |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Synchronous read-address reset, active low |
| re_n | input | 1 | Read enable, active low |
| rdata | output | WIDTH | Registered read data |
| rdata_oe | output | 1 | Drive enable for the three-state output pad |

## Verification
A wrong write address corrupts data silently. It only appears at `rdata` when the affected word is read back, which can be a full line or a whole wrap of the array later. For this reason the stimulus fills all 5120 words and reads across the wrap point. A wrong read address or a wrong hold shows at `rdata` on the first enabled read clock after the fault. The bench therefore compares every enabled read against a reference memory that it updates from the port activity.

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
  parameter int DEPTH = 5120,
  parameter int WIDTH = 8
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             we_n,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             re_n,
  output logic [WIDTH-1:0] rdata,
  output logic             rdata_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    waddr, raddr;
  logic [WIDTH-1:0] q;

  wire [AW-1:0] waddr_nx = (waddr == LAST) ? '0 : waddr + AW'(1);
  wire [AW-1:0] raddr_nx = (raddr == LAST) ? '0 : raddr + AW'(1);

  always_ff @(posedge wclk)
    if (!wrst_n) waddr <= '0;
    else if (!we_n) begin
      mem[waddr] <= wdata;
      waddr      <= waddr_nx;
    end

  always_ff @(posedge rclk)
    if (!rrst_n) raddr <= '0;
    else if (!re_n) begin
      q     <= mem[raddr];
      raddr <= raddr_nx;
    end

  assign rdata    = q;
  assign rdata_oe = ~re_n;

  // R1
  wr_reset_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $rose(wrst_n) |-> waddr == '0);
  // R2
  wr_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    we_n |=> $stable(waddr));
  // R3
  wr_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    !we_n |=> waddr == (($past(waddr) == LAST) ? '0 : $past(waddr) + AW'(1)));
  // R4
  rd_reset_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(rrst_n) |-> raddr == '0);
  // R5
  rd_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re_n |=> raddr == (($past(raddr) == LAST) ? '0 : $past(raddr) + AW'(1)));
  // R6
  rd_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    re_n |=> $stable(raddr));
endmodule

// File: tb/line_delay_mem_tb.sv
`timescale 1ns/1ps
module line_delay_mem_tb_top;
  localparam real CLK_PERIOD = 10.0;
  localparam real RD_HALF    = 6.5;
  localparam int  DEPTH = 5120;
  localparam int  WIDTH = 8;

  logic wclk = 0, rclk = 0;
  logic wrst_n = 0, we_n = 1, rrst_n = 0, re_n = 1;
  logic [WIDTH-1:0] wdata = '0;
  logic [WIDTH-1:0] rdata;
  logic rdata_oe;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RD_HALF) rclk = ~rclk;

  line_delay_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .wclk(wclk), .wrst_n(wrst_n), .we_n(we_n), .wdata(wdata),
    .rclk(rclk), .rrst_n(rrst_n), .re_n(re_n),
    .rdata(rdata), .rdata_oe(rdata_oe));

  int checks = 0, fails = 0;
  string tag = "R4";
  bit known = 0, done = 0;
  logic [WIDTH-1:0] m_mem [DEPTH];
  int m_wa = 0, m_ra = 0;
  logic [WIDTH-1:0] exp_q = '0;

  function automatic int step(int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  // reference model built from R1-style rules: reset wins, enable steps, wrap at end
  always @(posedge wclk)
    if (!wrst_n) m_wa = 0;
    else if (!we_n) begin m_mem[m_wa] = wdata; m_wa = step(m_wa); end

  always @(posedge rclk)
    if (!rrst_n) m_ra = 0;
    else if (!re_n) begin exp_q = m_mem[m_ra]; known = 1; m_ra = step(m_ra); end

  always @(negedge rclk) begin
    #1;
    if (!done) begin
      checks++;
      if (rdata_oe !== ~re_n) begin
        fails++;
        $display("FAIL R7 (%s): rdata_oe=%b expected %b", tag, rdata_oe, ~re_n);
      end
      if (!re_n && known) begin
        checks++;
        if (rdata !== exp_q) begin
          fails++;
          $display("FAIL %s: rdata=%h expected %h", tag, rdata, exp_q);
        end
      end
    end
  end

  task automatic wr(input bit rst_n, input bit en_n, input logic [WIDTH-1:0] d);
    @(negedge wclk); wrst_n = rst_n; we_n = en_n; wdata = d;
  endtask
  task automatic rd(input bit rst_n, input bit en_n);
    @(negedge rclk); rrst_n = rst_n; re_n = en_n;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // reset state: R1, R4, output floated (R7)
    repeat (3) wr(0, 1, 8'h00);
    repeat (3) rd(0, 1);
    // R8: write reset with enable low must not store 8'hEE
    wr(0, 0, 8'hEE);
    // R1/R2: write 20 words with gaps
    for (int i = 0; i < 20; i++) begin
      wr(1, 0, 8'(8'h10 + i));
      if (i % 4 == 3) wr(1, 1, 8'hFF);
    end
    wr(1, 1, 8'h00);
    // R4/R5 readback; R6 pauses; R8 read reset with enable low
    tag = "R5";
    rd(0, 0);
    for (int i = 0; i < 8; i++) rd(1, 0);
    tag = "R6";
    repeat (3) rd(1, 1);
    rd(1, 0);
    tag = "R8";
    rd(0, 0);
    tag = "R4";
    for (int i = 0; i < 12; i++) rd(1, 0);
    rd(1, 1);
    // R3: fill the whole array and past the wrap point
    tag = "R3";
    wr(0, 1, 8'h00);
    for (int i = 0; i < DEPTH + 6; i++) wr(1, 0, 8'($urandom));
    wr(1, 1, 8'h00);
    rd(0, 1);
    for (int i = 0; i < DEPTH + 6; i++) rd(1, 0);
    rd(1, 1);
    // R9: line delay set by reset spacing, both sides streaming
    tag = "R9";
    fork
      begin
        wr(0, 1, 8'h00);
        for (int i = 0; i < 300; i++) wr(1, 0, 8'($urandom));
      end
      begin
        repeat (40) rd(1, 1);
        rd(0, 1);
        for (int i = 0; i < 200; i++) rd(1, 0);
      end
    join
    // random mix of enables and occasional resets on both sides
    tag = "R9 random";
    fork
      for (int i = 0; i < 3000; i++)
        wr(($urandom % 150) != 0, ($urandom % 4) == 0, 8'($urandom));
      for (int i = 0; i < 2500; i++)
        rd(($urandom % 150) != 0, ($urandom % 3) == 0);
    join
    rd(1, 1);
    @(negedge rclk); #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule